// File: doc/BRIEF.md
# Paged Program Sequencer Stack

This block holds the program counter of a small controller with an 11-bit program address, together with a three-entry hardware return stack. An external decoder presents one control code per instruction slot, with the instruction's first byte, its operand byte, and an 8-bit table index (the accumulator and memory nibble joined). The block drives the program address and works out every change of flow: long jumps and calls, short jumps inside the current 64-byte page, one-byte calls into a fixed subroutine page, return, return-and-skip, and two table-lookup forms that spend one extra cycle reading program memory.

Program memory is treated as pages of 64 bytes and blocks of 256 bytes. Sequential flow ignores these boundaries. The short forms and the lookups depend on them. While the PC lies in the subroutine pages (addresses 0x080 to 0x0FF), the one-byte jump reaches 128 bytes instead of 64. A skip request from the executing instruction, or a return-and-skip, makes the block step over the next instruction, including its operand byte.

Top module: `pseq_top`

## Requirements
- R1: After reset the address is 0, no lookup is in progress, no skip is pending, and all three stack entries hold 0. A return straight after reset therefore goes to 0. Code 0 means no instruction, and it leaves all state unchanged.
- R2: Code 1 (one-byte, no transfer) adds 1 to the address. Code 2 (two-byte, no transfer) adds 2. The sum wraps modulo 2048 and crosses page and block boundaries.
- R3: Code 3 (long jump) loads the address with {byte0[2:0], byte1}. Code 4 (long call) does the same after pushing the address of the instruction that follows, which is the current address plus 2.
- R4: Code 6 (return) loads the address from the top entry and moves the second and third entries up one place. The third entry keeps its value. A push moves the entries down one place, so that a fourth push drops the oldest entry.
- R5: Code 7 (return and skip) pops the stack like code 6 and always sets a pending skip.
- R6: A skip_req at a code 1 or 2 sets the pending skip. The next instruction (code other than 0) is not executed: only its length (2 for codes 2, 3 and 4, otherwise 1) is added to the address, and the pending skip clears. skip_req has no effect with any other code.
- R7: Code 5 (short form) outside addresses 0x080 to 0x0FF: if byte0[7:6]=11, address[5:0] becomes byte0[5:0]. If byte0[7:6]=10, the block pushes address+1 and the address becomes 0x080 + byte0[5:0].
- R8: Code 5 while address[10:7]=0001: address[6:0] becomes byte0[6:0] for either value of byte0[7:6], and nothing is pushed.
- R9: Code 8 (indirect jump) drives {(address+1)[10:8], table index} for one cycle, with lookup_busy high. The address then becomes that block with tbl_data as the low byte.
- R10: Code 9 (table load) pushes address+1 and then drives {(address+1)[10:8], table index} for one busy cycle, with q_load high and q_data equal to tbl_data. It then pops, so the net effect is address+1, first and second entries unchanged, and the third entry equal to the old second entry.
- R11: Every input except tbl_data is ignored while lookup_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_kind | input | 4 | Control code of the instruction in this slot (0 to 9) |
| op_byte0 | input | 8 | First byte of the instruction |
| op_byte1 | input | 8 | Operand byte of a two-byte instruction |
| tbl_index | input | 8 | Low 8 bits of the lookup address |
| skip_req | input | 1 | The executing instruction asks to skip the next one |
| tbl_data | input | 8 | Program memory byte at rom_addr, same cycle |
| rom_addr | output | 11 | Program address (PC, or lookup address while busy) |
| lookup_busy | output | 1 | Lookup cycle in progress |
| skip_pend | output | 1 | The next instruction will be skipped |
| q_load | output | 1 | Table byte valid for the output latch |
| q_data | output | 8 | Table byte |

## Verification
A wrong stack entry does not show at once. It appears on rom_addr only at the return that reaches it, which can be up to three returns later, so the bench nests calls to full depth and beyond and then unwinds them all. A wrong lookup phase or skip flag shows on lookup_busy and skip_pend within one cycle. A wrong page or block field shows on rom_addr in the cycle after the transfer, so every transfer is placed near page and block edges and its result is compared every clock.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [3:0] {
        OP_IDLE  = 4'd0,
        OP_SEQ1  = 4'd1,
        OP_SEQ2  = 4'd2,
        OP_LJMP  = 4'd3,
        OP_LCALL = 4'd4,
        OP_SHORT = 4'd5,
        OP_RET   = 4'd6,
        OP_RETSK = 4'd7,
        OP_JIND  = 4'd8,
        OP_TBLQ  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_JIND = 2'd1,
        PH_TBLQ = 2'd2
    } phase_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/pseq_ret_stack.sv
module pseq_ret_stack #(
    parameter int AW    = 11,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top
);
    logic [AW-1:0] lvl_q [DEPTH];
    logic [AW-1:0] lvl_d [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        always_comb begin
            lvl_d[i] = lvl_q[i];
            if (push) begin
                if (i == 0) lvl_d[i] = push_val;
                else        lvl_d[i] = lvl_q[(i == 0) ? 0 : i-1];
            end else if (pop) begin
                if (i == DEPTH-1) lvl_d[i] = lvl_q[i];
                else              lvl_d[i] = lvl_q[(i == DEPTH-1) ? i : i+1];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[i] <= '0;
            else        lvl_q[i] <= lvl_d[i];
        end
    end

    assign top = lvl_q[0];

endmodule

// File: rtl/pseq_flow_dec.sv
module pseq_flow_dec
    import pseq_pkg::*;
#(
    parameter int AW       = 11,
    parameter int PGW      = 6,
    parameter int BLKW     = 8,
    parameter int SUB_PAGE = 2
) (
    input  logic [AW-1:0]   pc,
    input  op_e             op,
    input  logic [7:0]      b0,
    input  logic [7:0]      b1,
    input  logic [7:0]      idx,
    input  logic            skip_req,
    input  logic [AW-1:0]   stk_top,
    output logic [AW-1:0]   pc_inc,
    output logic [AW-1:0]   target,
    output logic            push,
    output logic            pop,
    output logic            set_skip,
    output phase_e          next_ph
);
    localparam int PGN = AW - PGW;
    localparam logic [PGN-1:0] SUB_PG = PGN'(SUB_PAGE);
    localparam logic [PGN-2:0] SUB_HI = SUB_PG[PGN-1:1];
    localparam int LJW = AW - BLKW;

    logic [1:0]    len;
    logic          in_sub;
    logic          is_call1;

    always_comb begin
        case (op)
            OP_SEQ2, OP_LJMP, OP_LCALL: len = 2'd2;
            default:                    len = 2'd1;
        endcase
    end

    assign pc_inc   = pc + AW'(len);
    assign in_sub   = (pc[AW-1:PGW+1] == SUB_HI);
    assign is_call1 = !in_sub && (b0[7:6] == 2'b10);

    always_comb begin
        target   = pc_inc;
        push     = 1'b0;
        pop      = 1'b0;
        set_skip = 1'b0;
        next_ph  = PH_RUN;
        unique case (op)
            OP_SEQ1, OP_SEQ2: begin
                set_skip = skip_req;
            end
            OP_LJMP: begin
                target = {b0[LJW-1:0], b1};
            end
            OP_LCALL: begin
                target = {b0[LJW-1:0], b1};
                push   = 1'b1;
            end
            OP_SHORT: begin
                if (in_sub) begin
                    target = {pc[AW-1:PGW+1], b0[PGW:0]};
                end else if (is_call1) begin
                    target = {SUB_PG, b0[PGW-1:0]};
                    push   = 1'b1;
                end else begin
                    target = {pc[AW-1:PGW], b0[PGW-1:0]};
                end
            end
            OP_RET: begin
                target = stk_top;
                pop    = 1'b1;
            end
            OP_RETSK: begin
                target   = stk_top;
                pop      = 1'b1;
                set_skip = 1'b1;
            end
            OP_JIND: begin
                target  = {pc_inc[AW-1:BLKW], idx};
                next_ph = PH_JIND;
            end
            OP_TBLQ: begin
                target  = {pc_inc[AW-1:BLKW], idx};
                push    = 1'b1;
                next_ph = PH_TBLQ;
            end
            default: begin
                target = pc;
            end
        endcase
    end

endmodule

// File: rtl/pseq_top.sv
module pseq_top
    import pseq_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DEPTH    = 3,
    parameter int PGW      = 6,
    parameter int BLKW     = 8,
    parameter int SUB_PAGE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_kind,
    input  logic [7:0]    op_byte0,
    input  logic [7:0]    op_byte1,
    input  logic [7:0]    tbl_index,
    input  logic          skip_req,
    input  logic [7:0]    tbl_data,
    output logic [AW-1:0] rom_addr,
    output logic          lookup_busy,
    output logic          skip_pend,
    output logic          q_load,
    output logic [7:0]    q_data
);
    typedef struct packed {
        logic [AW-1:0] pc;
        phase_e        ph;
        logic          skip;
    } seq_t;

    seq_t st_d, st_q;

    op_e           op;
    logic [AW-1:0] dec_inc, dec_target, stk_top;
    logic          dec_push, dec_pop, dec_skip;
    phase_e        dec_ph;
    logic          stk_push, stk_pop;

    assign op = op_e'(op_kind);

    pseq_flow_dec #(
        .AW(AW), .PGW(PGW), .BLKW(BLKW), .SUB_PAGE(SUB_PAGE)
    ) dec_i (
        .pc       (st_q.pc),
        .op       (op),
        .b0       (op_byte0),
        .b1       (op_byte1),
        .idx      (tbl_index),
        .skip_req (skip_req),
        .stk_top  (stk_top),
        .pc_inc   (dec_inc),
        .target   (dec_target),
        .push     (dec_push),
        .pop      (dec_pop),
        .set_skip (dec_skip),
        .next_ph  (dec_ph)
    );

    pseq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) stk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (dec_inc),
        .top      (stk_top)
    );

    always_comb begin
        st_d     = st_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        q_load   = 1'b0;
        unique case (st_q.ph)
            PH_RUN: begin
                if (op != OP_IDLE) begin
                    if (st_q.skip) begin
                        st_d.pc   = dec_inc;
                        st_d.skip = 1'b0;
                    end else begin
                        st_d.pc   = dec_target;
                        st_d.skip = dec_skip;
                        st_d.ph   = dec_ph;
                        stk_push  = dec_push;
                        stk_pop   = dec_pop;
                    end
                end
            end
            PH_JIND: begin
                st_d.pc = {st_q.pc[AW-1:BLKW], tbl_data};
                st_d.ph = PH_RUN;
            end
            PH_TBLQ: begin
                q_load  = 1'b1;
                stk_pop = 1'b1;
                st_d.pc = stk_top;
                st_d.ph = PH_RUN;
            end
            default: begin
                st_d.ph = PH_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc   <= '0;
            st_q.ph   <= PH_RUN;
            st_q.skip <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_addr    = st_q.pc;
    assign lookup_busy = (st_q.ph != PH_RUN);
    assign skip_pend   = st_q.skip;
    assign q_data      = tbl_data;

endmodule

// File: rtl/pseq_chk.sv
module pseq_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_kind,
    input logic [7:0]    op_byte0,
    input logic [7:0]    op_byte1,
    input logic [AW-1:0] rom_addr,
    input logic          lookup_busy,
    input logic          skip_pend,
    input logic          q_load
);
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!lookup_busy && op_kind == 4'd1) |=> rom_addr == AW'($past(rom_addr) + 1)); // R2
    AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!lookup_busy && !skip_pend && op_kind == 4'd3)
        |=> rom_addr == {$past(op_byte0[AW-9:0]), $past(op_byte1)}); // R3
    AST_RETSK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lookup_busy && !skip_pend && op_kind == 4'd7) |=> skip_pend); // R5
    AST_SKIP_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!lookup_busy && skip_pend && op_kind != 4'd0) |=> !skip_pend && !lookup_busy); // R6
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_busy |=> !lookup_busy); // R9
    AST_QLOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q_load |-> lookup_busy); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lookup_busy && op_kind == 4'd0) |=> $stable(rom_addr) && $stable(skip_pend)); // R1
endmodule

bind pseq_top pseq_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_kind     (op_kind),
    .op_byte0    (op_byte0),
    .op_byte1    (op_byte1),
    .rom_addr    (rom_addr),
    .lookup_busy (lookup_busy),
    .skip_pend   (skip_pend),
    .q_load      (q_load)
);

// File: tb/pseq_top_tb_top.sv
module pseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_kind = '0;
    logic [7:0]  op_byte0 = '0, op_byte1 = '0, tbl_index = '0, tbl_data = '0;
    logic        skip_req = 1'b0;
    logic [10:0] rom_addr;
    logic        lookup_busy, skip_pend, q_load;
    logic [7:0]  q_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    int m_pc = 0, m_ph = 0, m_skip = 0;
    int stk[$] = '{0, 0, 0};

    always #10 clk = ~clk;

    pseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_byte0(op_byte0),
        .op_byte1(op_byte1), .tbl_index(tbl_index), .skip_req(skip_req),
        .tbl_data(tbl_data), .rom_addr(rom_addr), .lookup_busy(lookup_busy),
        .skip_pend(skip_pend), .q_load(q_load), .q_data(q_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int romf(int a);
        return (a * 37 + 11) & 255;
    endfunction

    function automatic string req_of(int op);
        if (m_ph == 1) return (op != 0) ? "R11" : "R9";
        if (m_ph == 2) return (op != 0) ? "R11" : "R10";
        if (m_skip != 0 && op != 0) return "R6";
        case (op)
            0: return "R1";
            1, 2: return "R2";
            3, 4: return "R3";
            5: return ((m_pc >> 7) == 1) ? "R8" : "R7";
            6: return "R4";
            7: return "R5";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void m_push(int v);
        stk.push_front(v & 'h7FF);
        void'(stk.pop_back());
    endfunction

    function automatic int m_pop();
        int v = stk[0];
        stk = '{stk[1], stk[2], stk[2]};
        return v;
    endfunction

    task automatic mdl(int op, int b0, int b1, int idx, int sk, int td);
        int len, inc;
        if (m_ph == 1) begin
            m_pc = (m_pc & 'h700) | td; m_ph = 0;
        end else if (m_ph == 2) begin
            m_pc = m_pop(); m_ph = 0;
        end else if (op != 0) begin
            len = (op == 2 || op == 3 || op == 4) ? 2 : 1;
            inc = (m_pc + len) & 'h7FF;
            if (m_skip != 0) begin
                m_pc = inc; m_skip = 0;
            end else begin
                case (op)
                    1, 2: begin m_pc = inc; m_skip = sk; end
                    3: m_pc = ((b0 & 7) << 8) | b1;
                    4: begin m_push(inc); m_pc = ((b0 & 7) << 8) | b1; end
                    5: begin
                        if ((m_pc >> 7) == 1) m_pc = (m_pc & 'h780) | (b0 & 'h7F);
                        else if ((b0 >> 6) == 2) begin m_push(inc); m_pc = 'h80 | (b0 & 63); end
                        else m_pc = (m_pc & 'h7C0) | (b0 & 63);
                    end
                    6: m_pc = m_pop();
                    7: begin m_pc = m_pop(); m_skip = 1; end
                    8: begin m_pc = (inc & 'h700) | idx; m_ph = 1; end
                    9: begin m_push(inc); m_pc = (inc & 'h700) | idx; m_ph = 2; end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic step(int op, int b0 = 0, int b1 = 0, int idx = 0, int sk = 0);
        int td;
        string r;
        @(negedge clk);
        td = romf(m_pc);
        op_kind = 4'(op); op_byte0 = 8'(b0); op_byte1 = 8'(b1);
        tbl_index = 8'(idx); skip_req = sk[0]; tbl_data = 8'(td);
        #1;
        r = req_of(op);
        chk(r, "rom_addr", int'(rom_addr), m_pc);
        chk(r, "lookup_busy", int'(lookup_busy), (m_ph != 0) ? 1 : 0);
        chk(r, "skip_pend", int'(skip_pend), m_skip);
        chk(r, "q_load", int'(q_load), (m_ph == 2) ? 1 : 0);
        if (m_ph == 2) chk("R10", "q_data", int'(q_data), td);
        @(posedge clk);
        mdl(op, b0, b1, idx, sk, td);
    endtask

    task automatic ljmp(int a);
        step(3, (a >> 8) & 7, a & 255);
    endtask

    initial begin
        int lf;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state, idle slots, return on the empty stack
        step(0); step(0); step(6); step(0);
        // R2: sequential steps across page, block and wrap edges
        step(1); step(2); step(1);
        ljmp('h03E); step(1); step(1); step(2);
        ljmp('h0FF); step(1); step(2);
        ljmp('h7FE); step(2); step(1);
        // R3: long call and return
        ljmp('h123); step(4, 'h05, 'h67); step(1); step(6); step(1);
        // R4: nesting past three levels then unwinding
        step(4, 1, 'h10); step(4, 2, 'h20); step(4, 3, 'h30); step(4, 4, 'h40);
        step(6); step(6); step(6); step(6); step(6);
        // R5: return and skip over a two-byte instruction
        ljmp('h200); step(4, 6, 0); step(7); step(2); step(1);
        // R6: skip request, skipped forms of every length, ignored skip_req
        step(1, 0, 0, 0, 1); step(3, 7, 'hFF); step(1);
        step(2, 0, 0, 0, 1); step(5, 'hC0); step(1);
        step(1, 0, 0, 0, 1); step(9, 0, 0, 'h44); step(1);
        step(5, 'hC3, 0, 0, 1); step(1);
        // R7: short jump and one-byte call outside subroutine pages
        ljmp('h17E); step(5, 'hC5); step(5, 'h9A); step(5, 'hC1); step(6);
        ljmp('h03F); step(5, 'h80);
        // R8: inside subroutine pages both top-bit forms are 7-bit jumps
        ljmp('h0A3); step(5, 'h85); step(5, 'hC5); step(5, 'hFF); step(1); step(6);
        // R9: indirect jump near a block edge
        ljmp('h2FF); step(8, 0, 0, 'h5A); step(0); step(1);
        ljmp('h345); step(8, 0, 0, 'h00); step(0);
        // R10: table load with a filled stack
        step(4, 1, 1); step(4, 2, 2); step(4, 3, 3);
        step(9, 0, 0, 'h21); step(0); step(6); step(6); step(6);
        // R11: inputs during a busy cycle are ignored
        step(8, 0, 0, 'h10); step(3, 5, 5); step(1);
        step(9, 0, 0, 'h20); step(7, 0, 0, 0, 1); step(1);
        // mixed sequence
        lf = 'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = ((lf >> 1) ^ (((lf & 1) != 0) ? 'hB400 : 0)) & 'hFFFF;
            step((lf % 10), (lf >> 3) & 255, (lf >> 5) & 255, (lf >> 7) & 255, (lf >> 11) & 1);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule